// File: doc/BRIEF.md
# UART receiver with line status

This block turns an asynchronous serial line into characters. A 16x oversampling tick, generated elsewhere, paces it. The character format comes from static line-control inputs: word length of five to eight bits, optional parity, even or odd parity, and stick parity. These are the same settings the companion transmitter uses. Each finished character goes into a one-entry receive buffer. A line status byte reports data ready, overrun, parity error, framing error and break.

Software, or a bus adapter in front of the block, reads the character with a one-cycle data-read strobe. Data ready drops on that strobe. A one-cycle status-read strobe clears the four error flags. The error flags are sticky, so they stay set across later characters until the status is read. A separate output is high whenever any error flag is set.

The state machine has seven states:
- IDLE waits for the line to go low.
- START confirms the start bit at mid-bit.
- DATA samples the data bits.
- PARITY samples the parity bit.
- STOP samples the first stop bit.
- HOLD_LOW is entered when the stop bit is low. It waits to learn whether the low is a plain framing error or a break.
- WAIT_HIGH holds off after a break until the line returns high.

The transitions are:
- IDLE→START on a low line.
- START→IDLE on a false start.
- START→DATA on a confirmed start.
- DATA→PARITY or DATA→STOP after the last data bit.
- PARITY→STOP.
- STOP→IDLE on a valid stop bit.
- STOP→HOLD_LOW on a low stop bit.
- HOLD_LOW→IDLE when the line rises.
- HOLD_LOW→WAIT_HIGH when the low run becomes a break.
- WAIT_HIGH→IDLE when the line rises.

Top module: `uart_rx_lsr`

## Requirements
- R1: After reset the status byte reads 0x60, the received data reads 0 and the error output is low.
- R2: A low pulse on the line that is high again 8 ticks after the falling edge is discarded and changes no output.
- R3: Bits arrive LSB first, 16 ticks apart after the mid-start sample. The word length code is 00=5, 01=6, 10=7 or 11=8 bits, and data bits above the word length read 0. A finished character sets data ready (status bit 0).
- R4: With parity enabled, the expected parity bit is as follows. In even mode it is the XOR of the data bits. In odd mode it is the inverse of that XOR. In stick mode it equals the even-select input. A mismatch sets the parity error flag (status bit 2).
- R5: Only the first stop bit is checked, so a new start bit may follow it at once. A low first stop bit sets the framing error flag (status bit 3), and the character is still stored.
- R6: A character that finishes while data ready is set overwrites the buffer and sets the overrun flag (status bit 1).
- R7: A line held low for more than 176 ticks loads one character of all zeros. That character sets data ready, break (status bit 4) and framing error. No further character is taken until the line goes high.
- R8: The data-read strobe clears only data ready. The status-read strobe clears overrun, parity, framing and break, and leaves data ready unchanged.
- R9: The error output equals the OR of the overrun, parity, framing and break flags.
- R10: Status bits 5 and 6 always read 1, and bit 7 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rxd | input | 1 | Serial input, idle high |
| tick16 | input | 1 | One-cycle pulse at 16x the bit rate |
| wlen | input | 2 | Word length code |
| par_en | input | 1 | Parity bit present and checked |
| par_even | input | 1 | Even parity select; stick parity value |
| par_stick | input | 1 | Stick parity mode |
| rd_data | input | 1 | Receive buffer read strobe |
| rd_status | input | 1 | Line status read strobe |
| rx_data | output | 8 | Receive buffer contents |
| line_status | output | 8 | Line status byte |
| rx_err | output | 1 | Any error flag set |

## Verification
The bench covers the following corner cases:
- **Overrun from back-to-back frames.** Frames are sent with only one stop bit between them and no read in between. This exposes a receiver that insists on a second stop bit, and one that fails to raise overrun.
- **Framing error with valid data.** A frame with a low stop bit and non-zero data checks two faults: dropping the character, and confusing a framing error with a break.
- **Long break.** A break far longer than the threshold catches a receiver that loads repeated zero characters.
- **Glitch.** A short low glitch catches a receiver that starts a character without confirming the start bit at mid-bit.
- **Parity.** Stick and odd parity, sent with a wrong parity bit, catch an inverted or misplaced parity rule.

// File: rtl/uart_rx_pkg.sv
`timescale 1ns/1ps
package uart_rx_pkg;
    localparam int DATA_W = 8;
    localparam int MIN_W  = 5;

    localparam int LSR_DR   = 0;
    localparam int LSR_OE   = 1;
    localparam int LSR_PE   = 2;
    localparam int LSR_FE   = 3;
    localparam int LSR_BI   = 4;
    localparam int LSR_THRE = 5;
    localparam int LSR_TEMT = 6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP,
        ST_HOLD_LOW,
        ST_WAIT_HIGH
    } rx_state_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              pe;
        logic              fe;
        logic              bi;
    } rx_char_t;
endpackage

// File: rtl/rx_sync.sv
`timescale 1ns/1ps
module rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    generate
        if (STAGES <= 1) begin : g_single
            logic ff;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) ff <= 1'b1;
                else        ff <= d;
            end
            assign q = ff;
        end else begin : g_chain
            logic [STAGES-1:0] ff;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) ff <= '1;
                else        ff <= {ff[STAGES-2:0], d};
            end
            assign q = ff[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/rx_brk_det.sv
`timescale 1ns/1ps
module rx_brk_det #(
    parameter int OSR      = 16,
    parameter int MAX_BITS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx,
    input  logic tick,
    output logic long_low
);
    // longest frame: start + data + parity + stop; break needs strictly more
    localparam int LIMIT = OSR * (MAX_BITS + 3) + 1;
    localparam int W     = $clog2(LIMIT + 1);

    logic [W-1:0] low_cnt;

    assign long_low = (low_cnt == W'(LIMIT));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 low_cnt <= '0;
        else if (rx)                low_cnt <= '0;
        else if (tick && !long_low) low_cnt <= low_cnt + 1'b1;
    end
endmodule

// File: rtl/rx_frame_fsm.sv
`timescale 1ns/1ps
module rx_frame_fsm
    import uart_rx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx,
    input  logic       tick,
    input  logic [1:0] wlen,
    input  logic       par_en,
    input  logic       par_even,
    input  logic       par_stick,
    input  logic       long_low,
    output logic       commit,
    output rx_char_t   chr
);
    localparam int CW  = $clog2(OSR);
    localparam int IW  = $clog2(DATA_W);
    localparam int MID = OSR / 2 - 1;
    localparam int LST = OSR - 1;

    rx_state_e         state, st_n;
    logic [CW-1:0]     cnt, cnt_n;
    logic [IW-1:0]     idx, idx_n;
    logic [DATA_W-1:0] shreg, sh_n;
    logic              par_acc, pa_n;
    logic              par_bad, pb_n;

    logic          confirm, sample, exp_par;
    logic [IW-1:0] last_idx;

    assign confirm  = tick && (cnt == CW'(MID));
    assign sample   = tick && (cnt == CW'(LST));
    assign last_idx = IW'(MIN_W - 1) + IW'(wlen);
    assign exp_par  = par_stick ? par_even : (par_even ? par_acc : ~par_acc);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            idx     <= '0;
            shreg   <= '0;
            par_acc <= 1'b0;
            par_bad <= 1'b0;
        end else begin
            state   <= st_n;
            cnt     <= cnt_n;
            idx     <= idx_n;
            shreg   <= sh_n;
            par_acc <= pa_n;
            par_bad <= pb_n;
        end
    end

    // next state
    always_comb begin
        st_n  = state;
        cnt_n = tick ? cnt + 1'b1 : cnt;
        idx_n = idx;
        sh_n  = shreg;
        pa_n  = par_acc;
        pb_n  = par_bad;
        unique case (state)
            ST_IDLE: begin
                cnt_n = '0;
                if (!rx) st_n = ST_START;
            end
            ST_START: begin
                if (confirm) begin
                    cnt_n = '0;
                    if (rx) begin
                        st_n = ST_IDLE;
                    end else begin
                        st_n  = ST_DATA;
                        idx_n = '0;
                        sh_n  = '0;
                        pa_n  = 1'b0;
                        pb_n  = 1'b0;
                    end
                end
            end
            ST_DATA: begin
                if (sample) begin
                    sh_n[idx] = rx;
                    pa_n      = par_acc ^ rx;
                    if (idx == last_idx) st_n = par_en ? ST_PARITY : ST_STOP;
                    else                 idx_n = idx + 1'b1;
                end
            end
            ST_PARITY: begin
                if (sample) begin
                    pb_n = (rx != exp_par);
                    st_n = ST_STOP;
                end
            end
            ST_STOP: begin
                if (sample) st_n = rx ? ST_IDLE : ST_HOLD_LOW;
            end
            ST_HOLD_LOW: begin
                if (rx)            st_n = ST_IDLE;
                else if (long_low) st_n = ST_WAIT_HIGH;
            end
            ST_WAIT_HIGH: begin
                if (rx) st_n = ST_IDLE;
            end
            default: st_n = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        commit   = 1'b0;
        chr.data = shreg;
        chr.pe   = par_bad;
        chr.fe   = 1'b0;
        chr.bi   = 1'b0;
        unique case (state)
            ST_STOP: begin
                if (sample && rx) commit = 1'b1;
            end
            ST_HOLD_LOW: begin
                if (rx) begin
                    commit = 1'b1;
                    chr.fe = 1'b1;
                end else if (long_low) begin
                    commit   = 1'b1;
                    chr.fe   = 1'b1;
                    chr.bi   = 1'b1;
                    chr.pe   = 1'b0;
                    chr.data = '0;
                end
            end
            default: ;
        endcase
    end

    // R7
    brk_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && chr.bi) |-> long_low);
endmodule

// File: rtl/rx_lsr.sv
`timescale 1ns/1ps
module rx_lsr
    import uart_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  rx_char_t          chr,
    input  logic              rd_data,
    input  logic              rd_status,
    output logic [DATA_W-1:0] rx_data,
    output logic [7:0]        status
);
    logic [DATA_W-1:0] buf_q;
    logic dr, oe, pe, fe, bi;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q <= '0;
            dr    <= 1'b0;
            oe    <= 1'b0;
            pe    <= 1'b0;
            fe    <= 1'b0;
            bi    <= 1'b0;
        end else begin
            if (commit) buf_q <= chr.data;
            dr <= commit | (dr & ~rd_data);
            oe <= (commit & dr & ~rd_data) | (oe & ~rd_status);
            pe <= (commit & chr.pe) | (pe & ~rd_status);
            fe <= (commit & chr.fe) | (fe & ~rd_status);
            bi <= (commit & chr.bi) | (bi & ~rd_status);
        end
    end

    always_comb begin
        status           = '0;
        status[LSR_DR]   = dr;
        status[LSR_OE]   = oe;
        status[LSR_PE]   = pe;
        status[LSR_FE]   = fe;
        status[LSR_BI]   = bi;
        status[LSR_THRE] = 1'b1;
        status[LSR_TEMT] = 1'b1;
    end

    assign rx_data = buf_q;

    // R3
    dr_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dr) |-> $past(commit));
    // R6
    oe_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe) |-> $past(commit && dr));
    // R8
    dr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && !commit) |=> !dr);
    // R8
    err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_status && !commit) |=> !(oe || pe || fe || bi));
    // R7
    bi_fe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bi |-> fe);
endmodule

// File: rtl/uart_rx_lsr.sv
`timescale 1ns/1ps
module uart_rx_lsr
    import uart_rx_pkg::*;
#(
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rxd,
    input  logic       tick16,
    input  logic [1:0] wlen,
    input  logic       par_en,
    input  logic       par_even,
    input  logic       par_stick,
    input  logic       rd_data,
    input  logic       rd_status,
    output logic [7:0] rx_data,
    output logic [7:0] line_status,
    output logic       rx_err
);
    logic     rx_s, long_low, commit;
    rx_char_t chr;

    rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(rxd), .q(rx_s)
    );

    rx_brk_det #(.OSR(OSR), .MAX_BITS(DATA_W)) u_brk (
        .clk(clk), .rst_n(rst_n), .rx(rx_s), .tick(tick16), .long_low(long_low)
    );

    rx_frame_fsm #(.OSR(OSR)) u_fsm (
        .clk(clk), .rst_n(rst_n), .rx(rx_s), .tick(tick16),
        .wlen(wlen), .par_en(par_en), .par_even(par_even), .par_stick(par_stick),
        .long_low(long_low), .commit(commit), .chr(chr)
    );

    rx_lsr u_lsr (
        .clk(clk), .rst_n(rst_n), .commit(commit), .chr(chr),
        .rd_data(rd_data), .rd_status(rd_status),
        .rx_data(rx_data), .status(line_status)
    );

    assign rx_err = line_status[LSR_OE] | line_status[LSR_PE]
                  | line_status[LSR_FE] | line_status[LSR_BI];
endmodule

// File: tb/test_uart_rx_lsr.sv
`timescale 1ns/1ps
module test_uart_rx_lsr;
    localparam int BITC = 32;   // 16 ticks per bit, one tick every 2 clocks

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rxd = 1'b1;
    logic tick16 = 1'b0;
    logic [1:0] wlen = 2'b11;
    logic par_en = 1'b0, par_even = 1'b0, par_stick = 1'b0;
    logic rd_data = 1'b0, rd_status = 1'b0;
    logic [7:0] rx_data, line_status;
    logic rx_err;

    int checks = 0;
    int failures = 0;
    bit hold = 1'b0;
    bit finished = 1'b0;

    // behavioural model
    logic [7:0] m_data = 8'h00;
    bit m_dr = 0, m_oe = 0, m_pe = 0, m_fe = 0, m_bi = 0;

    uart_rx_lsr i_uart_rx_lsr (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .tick16(tick16),
        .wlen(wlen), .par_en(par_en), .par_even(par_even), .par_stick(par_stick),
        .rd_data(rd_data), .rd_status(rd_status),
        .rx_data(rx_data), .line_status(line_status), .rx_err(rx_err)
    );

    always #2.5 clk = ~clk;

    always @(negedge clk) if (rst_n) tick16 <= ~tick16;

    task automatic chk(input string tag, input string what, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, got, exp, $time);
        end
    endtask

    // per-clock comparison against the model
    always @(posedge clk) begin
        #1;
        if (rst_n && !hold && !finished) begin
            chk("R3", "data", rx_data, m_data);
            chk("R3", "ready", {7'b0, line_status[0]}, {7'b0, m_dr});
            chk("R6", "overrun", {7'b0, line_status[1]}, {7'b0, m_oe});
            chk("R4", "parity err", {7'b0, line_status[2]}, {7'b0, m_pe});
            chk("R5", "framing err", {7'b0, line_status[3]}, {7'b0, m_fe});
            chk("R7", "break", {7'b0, line_status[4]}, {7'b0, m_bi});
            chk("R10", "fixed bits", {5'b0, line_status[7:5]}, 8'h03);
            chk("R9", "err out", {7'b0, rx_err}, {7'b0, (m_oe | m_pe | m_fe | m_bi)});
        end
    end

    task automatic drive(input logic lvl, input int clocks);
        rxd = lvl;
        repeat (clocks) @(negedge clk);
    endtask

    task automatic model_commit(input logic [7:0] d, input bit pe, input bit fe, input bit bi);
        if (m_dr) m_oe = 1;
        m_data = d;
        m_dr = 1;
        m_pe = m_pe | pe;
        m_fe = m_fe | fe;
        m_bi = m_bi | bi;
    endtask

    function automatic logic parity_of(input logic [7:0] d, input int n, input logic even, input logic stick);
        logic x = 1'b0;
        if (stick) return even;
        for (int i = 0; i < n; i++) x ^= d[i];
        return even ? x : ~x;
    endfunction

    // sends start, n data bits, optional parity (flipped if bad_par), first stop bit
    task automatic send_frame(input logic [7:0] d, input int n, input bit bad_par,
                              input logic stop_lvl, input int post);
        logic pbit;
        logic [7:0] mask;
        pbit = parity_of(d, n, par_even, par_stick) ^ bad_par;
        mask = 8'((16'h1 << n) - 1);
        drive(1'b0, BITC);
        for (int i = 0; i < n; i++) drive(d[i], BITC);
        if (par_en) drive(pbit, BITC);
        hold = 1;
        drive(stop_lvl, BITC);
        if (!stop_lvl) drive(1'b1, 8);
        model_commit(d & mask, par_en && bad_par, !stop_lvl, 0);
        hold = 0;
        drive(1'b1, post);
    endtask

    task automatic read_data();
        rd_data = 1'b1;
        @(posedge clk);
        m_dr = 0;
        @(negedge clk);
        rd_data = 1'b0;
    endtask

    task automatic read_status();
        rd_status = 1'b1;
        @(posedge clk);
        m_oe = 0; m_pe = 0; m_fe = 0; m_bi = 0;
        @(negedge clk);
        rd_status = 1'b0;
    endtask

    task automatic report();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            failures++;
            $display("FAIL watchdog: run hung actual=running expected=done");
            report();
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 / R10 reset state
        chk("R1", "reset status", line_status, 8'h60);
        chk("R1", "reset data", rx_data, 8'h00);
        chk("R1", "reset err", {7'b0, rx_err}, 8'h00);
        drive(1'b1, 40);

        // R3 eight bits, no parity
        wlen = 2'b11; par_en = 0;
        send_frame(8'hA5, 8, 0, 1'b1, 40);
        chk("R3", "8-bit char", rx_data, 8'hA5);
        chk("R3", "ready set", line_status, 8'h61);
        read_data();
        chk("R8", "data read clears ready", line_status, 8'h60);
        chk("R8", "data kept after read", rx_data, 8'hA5);

        // R3 five bits: upper bits zero
        wlen = 2'b00;
        send_frame(8'h3B, 5, 0, 1'b1, 40);
        chk("R3", "5-bit char", rx_data, 8'h1B);
        read_data();

        // R4 parity modes
        wlen = 2'b10; par_en = 1; par_even = 1; par_stick = 0;
        send_frame(8'h55, 7, 0, 1'b1, 40);
        chk("R4", "even good parity", line_status, 8'h61);
        read_data();
        par_even = 0;
        send_frame(8'h13, 7, 1, 1'b1, 40);
        chk("R4", "odd bad parity", line_status, 8'h65);
        read_status();
        chk("R8", "status read keeps ready", line_status, 8'h61);
        read_data();
        wlen = 2'b01; par_stick = 1; par_even = 1;
        send_frame(8'h2A, 6, 0, 1'b1, 40);
        chk("R4", "stick good parity", line_status, 8'h61);
        read_data();
        send_frame(8'h2A, 6, 1, 1'b1, 40);
        chk("R4", "stick bad parity", line_status, 8'h65);
        read_status();
        read_data();

        // R5 / R6 back-to-back frames after one stop bit, no read in between
        wlen = 2'b11; par_en = 0; par_stick = 0;
        send_frame(8'h11, 8, 0, 1'b1, 0);
        send_frame(8'hC3, 8, 0, 1'b1, 40);
        chk("R6", "overrun data", rx_data, 8'hC3);
        chk("R6", "overrun flag", line_status, 8'h63);
        chk("R9", "err on overrun", {7'b0, rx_err}, 8'h01);
        read_status();
        read_data();

        // R5 framing error keeps data
        send_frame(8'h5A, 8, 0, 1'b0, 40);
        chk("R5", "fe data", rx_data, 8'h5A);
        chk("R5", "fe flag", line_status, 8'h69);
        read_status();
        read_data();

        // R2 glitch shorter than half a bit
        drive(1'b0, 8);
        drive(1'b1, 400);
        chk("R2", "glitch ignored", line_status, 8'h60);
        chk("R2", "glitch data", rx_data, 8'h5A);

        // R7 long break gives one zero character
        hold = 1;
        drive(1'b0, 800);
        drive(1'b1, 8);
        model_commit(8'h00, 0, 1, 1);
        hold = 0;
        drive(1'b1, 40);
        chk("R7", "break data", rx_data, 8'h00);
        chk("R7", "break status", line_status, 8'h79);
        read_status();
        chk("R8", "break cleared", line_status, 8'h61);
        read_data();

        // receiver recovers after break
        send_frame(8'h81, 8, 0, 1'b1, 40);
        chk("R3", "after break", rx_data, 8'h81);
        chk("R3", "after break status", line_status, 8'h61);

        finished = 1;
        report();
    end
endmodule